// File: doc/BRIEF.md
# Raster Dot and Scanline Timing Generator

This block is the timing backbone of a tile-based video processor. It counts pixel dots within a scanline and scanlines within a frame. From its position it marks the visible lines, the post-render lines, the vertical-blank interval and the pre-render line. It keeps a vertical-blank status flag. When the vertical-blank interrupt is enabled, it sends a one-cycle interrupt pulse to the host processor.

It also drives a strobe that clears the sprite-attribute address pointer while sprites load for the next line. It keeps a frame counter and a frame-parity bit. When background or sprite rendering is on, each odd frame is one dot shorter, which keeps the picture phase in step with the colour carrier.

Outputs are registered counters plus the events decoded from them. The surrounding fetch and render logic follows the dot and line outputs. The host reads the flag and takes the interrupt pulse.

Top module: `raster_timing_gen`

## Requirements
- R1: The dot counter runs 0, 1, ..., 340 and then returns to 0 while the line counter advances by one, so a line has 341 dots.
- R2: The line counter runs 0 to 261 and then returns to 0, so a frame has 262 lines. The line only changes on the edge that takes the dot counter to 0.
- R3: On the clock edge that leaves dot 1 of line 241, the vertical-blank flag becomes 1. The flag is therefore first seen high at line 241, dot 2. It stays high until R4 clears it.
- R4: On the clock edge that leaves dot 1 of line 261, the flag becomes 0. The flag is therefore first seen low at line 261, dot 2.
- R5: `vblank_irq_o` is high for exactly one cycle, the same cycle in which the flag first reads high. This happens only if `irq_en_i` was 1 while the position was line 241, dot 1. Otherwise it stays low for the whole frame.
- R6: `spr_addr_clr_o` is high exactly when the dot is between 257 and 320 inclusive and the line is either 0 to 239 or 261. It is low at every other position.
- R7: On an odd frame (parity 1), if `bg_en_i` or `spr_en_i` is 1 at line 261, dot 339, the next position is line 0, dot 0. In every other case, line 261 runs through dot 340.
- R8: Each return to line 0 toggles `odd_frame_o` and increments `frame_o`, which wraps modulo 2^16.
- R9: While `rst` is high, the dot, line, frame, parity, flag and interrupt outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| bg_en_i | input | 1 | Background rendering enabled |
| spr_en_i | input | 1 | Sprite rendering enabled |
| irq_en_i | input | 1 | Vertical-blank interrupt enable |
| dot_o | output | 9 | Current dot within the line |
| line_o | output | 9 | Current scanline within the frame |
| frame_o | output | 16 | Frame counter |
| odd_frame_o | output | 1 | Frame parity, 1 on odd frames |
| vblank_o | output | 1 | Vertical-blank status flag |
| vblank_irq_o | output | 1 | One-cycle interrupt request |
| spr_addr_clr_o | output | 1 | Sprite-attribute address clear strobe |

## Verification
The bench runs an even frame with rendering on and the interrupt off. A design that drops the parity term would shorten this frame, and one that ignores the enable would still fire the pulse. It then runs an odd frame with rendering on and the interrupt on. Here a missing skip leaves every later position one dot behind, and a late or stretched pulse misses the cycle in which the flag rises. Each cycle compares the flag edges at dot 2 of lines 241 and 261 and the clear-strobe window limits at dots 256/257 and 320/321. These comparisons catch off-by-one decoding, and also a strobe leaking into the post-render or blanking lines.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int POS_W = 9;

    typedef logic [POS_W-1:0] pos_cnt_t;

    typedef struct packed {
        pos_cnt_t dot;
        pos_cnt_t line;
    } raster_pos_t;

    typedef struct packed {
        logic vbl_set;
        logic vbl_clr;
        logic spr_clr;
    } raster_evt_t;

    function automatic logic in_span(input pos_cnt_t v, input int lo, input int hi);
        return (int'(v) >= lo) && (int'(v) <= hi);
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int DOTS    = 341,
    parameter int LINES   = 262,
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               render_en,
    output raster_pos_t        pos,
    output logic               odd,
    output logic [FRAME_W-1:0] frame
);
    localparam int LAST_DOT  = DOTS - 1;
    localparam int SKIP_DOT  = DOTS - 2;
    localparam int LAST_LINE = LINES - 1;

    logic end_of_line;
    logic end_of_frame;

    always_comb begin
        end_of_line  = (int'(pos.dot) == LAST_DOT);
        end_of_frame = (int'(pos.line) == LAST_LINE) &&
                       (end_of_line || (odd && render_en && int'(pos.dot) == SKIP_DOT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            odd   <= 1'b0;
            frame <= '0;
        end else if (end_of_frame) begin
            pos   <= '0;
            odd   <= ~odd;
            frame <= frame + 1'b1;
        end else if (end_of_line) begin
            pos.dot  <= '0;
            pos.line <= pos.line + 1'b1;
        end else begin
            pos.dot <= pos.dot + 1'b1;
        end
    end
endmodule

// File: rtl/raster_event_decode.sv
module raster_event_decode
    import raster_pkg::*;
#(
    parameter int VISIBLE_LINES = 240,
    parameter int VBL_LINE      = 241,
    parameter int PRE_LINE      = 261,
    parameter int FLAG_DOT      = 1,
    parameter int SPR_FIRST     = 257,
    parameter int SPR_LAST      = 320
) (
    input  raster_pos_t pos,
    output raster_evt_t evt
);
    logic on_flag_dot;
    logic fetch_line;

    always_comb begin
        on_flag_dot  = (int'(pos.dot) == FLAG_DOT);
        fetch_line   = (int'(pos.line) < VISIBLE_LINES) || (int'(pos.line) == PRE_LINE);
        evt.vbl_set  = on_flag_dot && (int'(pos.line) == VBL_LINE);
        evt.vbl_clr  = on_flag_dot && (int'(pos.line) == PRE_LINE);
        evt.spr_clr  = fetch_line && in_span(pos.dot, SPR_FIRST, SPR_LAST);
    end
endmodule

// File: rtl/raster_vblank.sv
module raster_vblank
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  raster_evt_t evt,
    input  logic        irq_en,
    output logic        flag,
    output logic        irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= evt.vbl_set & irq_en;
            if (evt.vbl_set) begin
                flag <= 1'b1;
            end else if (evt.vbl_clr) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int DOTS          = 341,
    parameter int LINES         = 262,
    parameter int VISIBLE_LINES = 240,
    parameter int VBL_LINE      = 241,
    parameter int SPR_FIRST     = 257,
    parameter int SPR_LAST      = 320,
    parameter int FRAME_W       = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bg_en_i,
    input  logic               spr_en_i,
    input  logic               irq_en_i,
    output logic [POS_W-1:0]   dot_o,
    output logic [POS_W-1:0]   line_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               odd_frame_o,
    output logic               vblank_o,
    output logic               vblank_irq_o,
    output logic               spr_addr_clr_o
);
    localparam int PRE_LINE = LINES - 1;

    raster_pos_t pos;
    raster_evt_t evt;
    logic        render_en;

    assign render_en = bg_en_i | spr_en_i;

    raster_counter #(
        .DOTS(DOTS), .LINES(LINES), .FRAME_W(FRAME_W)
    ) u_cnt (
        .clk(clk), .rst(rst), .render_en(render_en),
        .pos(pos), .odd(odd_frame_o), .frame(frame_o)
    );

    raster_event_decode #(
        .VISIBLE_LINES(VISIBLE_LINES), .VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE),
        .FLAG_DOT(1), .SPR_FIRST(SPR_FIRST), .SPR_LAST(SPR_LAST)
    ) u_dec (
        .pos(pos), .evt(evt)
    );

    raster_vblank u_vbl (
        .clk(clk), .rst(rst), .evt(evt), .irq_en(irq_en_i),
        .flag(vblank_o), .irq(vblank_irq_o)
    );

    assign dot_o          = pos.dot;
    assign line_o         = pos.line;
    assign spr_addr_clr_o = evt.spr_clr;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int DOTS  = 341,
    parameter int LINES = 262
) (
    input logic       clk,
    input logic       rst,
    input logic [8:0] dot_o,
    input logic [8:0] line_o,
    input logic       vblank_o,
    input logic       vblank_irq_o,
    input logic       spr_addr_clr_o
);
    assert_dot_bound_R1: assert property (@(posedge clk) disable iff (rst)
        int'(dot_o) < DOTS);

    assert_dot_step_R1: assert property (@(posedge clk) disable iff (rst)
        (int'(dot_o) < DOTS - 2) |=> (dot_o == $past(dot_o) + 9'd1));

    assert_line_bound_R2: assert property (@(posedge clk) disable iff (rst)
        int'(line_o) < LINES);

    assert_line_moves_at_dot0_R2: assert property (@(posedge clk) disable iff (rst)
        (int'(dot_o) > 0) |=> (line_o == $past(line_o)) || (dot_o == 9'd0));

    assert_vbl_rise_pos_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank_o) |-> (line_o == 9'd241 && dot_o == 9'd2));

    assert_vbl_fall_pos_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(vblank_o) |-> (line_o == 9'd261 && dot_o == 9'd2));

    assert_irq_with_rise_R5: assert property (@(posedge clk) disable iff (rst)
        vblank_irq_o |-> $rose(vblank_o));

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
        vblank_irq_o |=> !vblank_irq_o);

    assert_spr_clr_region_R6: assert property (@(posedge clk) disable iff (rst)
        spr_addr_clr_o |-> !(line_o >= 9'd240 && line_o <= 9'd260));
endmodule

bind raster_timing_gen raster_timing_chk #(.DOTS(DOTS), .LINES(LINES)) u_chk (
    .clk(clk), .rst(rst), .dot_o(dot_o), .line_o(line_o),
    .vblank_o(vblank_o), .vblank_irq_o(vblank_irq_o),
    .spr_addr_clr_o(spr_addr_clr_o)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;

    typedef struct {
        int dot;
        int line;
        int odd;
        int frame;
        int vbl;
        int irq;
        int spr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bg_en_i = 1'b0;
    logic        spr_en_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic [8:0]  dot_o;
    logic [8:0]  line_o;
    logic [15:0] frame_o;
    logic        odd_frame_o;
    logic        vblank_o;
    logic        vblank_irq_o;
    logic        spr_addr_clr_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    bit finished = 1'b0;
    exp_t q[$];

    int m_dot = 0, m_line = 0, m_odd = 0, m_frame = 0, m_vbl = 0;

    always #2.5 clk = ~clk;

    raster_timing_gen dut (
        .clk(clk), .rst(rst), .bg_en_i(bg_en_i), .spr_en_i(spr_en_i),
        .irq_en_i(irq_en_i), .dot_o(dot_o), .line_o(line_o), .frame_o(frame_o),
        .odd_frame_o(odd_frame_o), .vblank_o(vblank_o),
        .vblank_irq_o(vblank_irq_o), .spr_addr_clr_o(spr_addr_clr_o)
    );

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp_v);
        end
    endtask

    // advance the reference model one clock and queue the expected outputs
    task automatic model_step();
        exp_t e;
        int irq_n;
        bit wrap;
        irq_n = (m_line == 241 && m_dot == 1 && irq_en_i) ? 1 : 0;
        if (m_line == 241 && m_dot == 1) m_vbl = 1;
        else if (m_line == 261 && m_dot == 1) m_vbl = 0;
        wrap = (m_line == 261) &&
               (m_dot == 340 || (m_dot == 339 && m_odd == 1 && (bg_en_i || spr_en_i)));
        if (wrap) begin
            m_dot = 0; m_line = 0; m_odd ^= 1; m_frame = (m_frame + 1) % 65536;
        end else if (m_dot == 340) begin
            m_dot = 0; m_line++;
        end else begin
            m_dot++;
        end
        e.dot = m_dot; e.line = m_line; e.odd = m_odd; e.frame = m_frame;
        e.vbl = m_vbl; e.irq = irq_n;
        e.spr = (m_dot >= 257 && m_dot <= 320 && (m_line < 240 || m_line == 261)) ? 1 : 0;
        q.push_back(e);
    endtask

    // driver
    initial begin
        repeat (4) @(negedge clk);
        check("R9 dot",   int'(dot_o), 0);
        check("R9 line",  int'(line_o), 0);
        check("R9 frame", int'(frame_o), 0);
        check("R9 odd",   int'(odd_frame_o), 0);
        check("R9 vbl",   int'(vblank_o), 0);
        check("R9 irq",   int'(vblank_irq_o), 0);
        // frame 0: even, rendering on, interrupt off (R7 no skip, R5 no pulse)
        bg_en_i = 1'b1;
        rst = 1'b0;
        model_step();
        while (!(m_frame == 2 && m_line == 1)) begin
            @(negedge clk);
            if (m_frame == 1) begin
                // frame 1: odd, sprites only, interrupt on (R7 skip, R5 pulse)
                bg_en_i  = 1'b0;
                spr_en_i = 1'b1;
                irq_en_i = 1'b1;
            end
            model_step();
        end
        @(negedge clk);
        done = 1'b1;
    end

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check("R1 dot",        int'(dot_o), e.dot);
                check("R2 line",       int'(line_o), e.line);
                check("R8 parity",     int'(odd_frame_o), e.odd);
                check("R8 frame",      int'(frame_o), e.frame);
                check("R3/R4 vblank",  int'(vblank_o), e.vbl);
                check("R5 irq",        int'(vblank_irq_o), e.irq);
                check("R6 spr clear",  int'(spr_addr_clr_o), e.spr);
                if (e.line == 0 && e.dot == 0 && e.frame == 2)
                    check("R7 short odd frame landed", int'(line_o) + int'(dot_o), 0);
            end
        end
    end

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (done && q.size() == 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        wait (cycles >= 199000);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule